// File: doc/BRIEF.md
# Single-Cycle Load/Store Processor Core

A 32-bit processor core that completes one instruction per clock for a nine-instruction load/store subset. The supported operations are add, sub, and, or, set-less-than, load word, store word, branch-if-equal and absolute jump. The core contains the program counter and a 32-entry register file with two operand read ports and one write port. It also holds an ALU with result, zero and overflow outputs, the immediate sign extension, the branch and jump address formation, the next-PC multiplexers and a combined main and ALU decoder. Instruction memory and data memory are small word arrays inside the block.

While reset is held, a preload port fills both memories. A select input steers each preload write to one array or the other, and the address is a word index. After reset is released the core fetches from byte address 0 and runs on its own. Two probe outputs let the surrounding logic read any architectural register and any data-memory word without disturbing execution.

Top module: `sc_core`

## Requirements
- R1: While rst_ni is low, pc_o is 0 and every register reads 0 through the probe.
- R2: With op 0, funct 32 (add), 34 (sub), 36 (and) or 37 (or) writes the result of rs op rt into register rd, using field positions op[31:26], rs[25:21], rt[20:16], rd[15:11] and funct[5:0].
- R3: With op 0 and funct 42 (slt), register rd receives 1 when rs is less than rt as signed 32-bit values, and 0 otherwise.
- R4: Op 35 loads the data word at byte address rs + sign-extended imm[15:0] into register rt.
- R5: Op 43 stores register rt at byte address rs + sign-extended imm[15:0] and writes no register.
- R6: For op 4, when rs equals rt the next PC is PC+4 + (sign-extended imm << 2). Otherwise it is PC+4.
- R7: Op 2 sets the next PC to {PC+4[31:28], target[25:0], 2'b00} and writes neither a register nor memory.
- R8: Register 0 always reads as 0. A write addressed to it is discarded.
- R9: An opcode outside {0, 2, 4, 35, 43}, or op 0 with a funct outside {32, 34, 36, 37, 42}, writes no register and no memory, and the PC advances by 4.
- R10: In every cycle after reset with no taken branch and no jump, the PC advances by exactly 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous active-low reset |
| load_we_i | input | 1 | Preload write strobe |
| load_imem_i | input | 1 | Preload target: 1 = instruction memory, 0 = data memory |
| load_addr_i | input | LAW | Preload word index, also the data-memory probe address |
| load_data_i | input | 32 | Preload write data |
| probe_reg_i | input | 5 | Register number to observe |
| probe_reg_o | output | 32 | Value of the probed register |
| probe_mem_o | output | 32 | Data-memory word at load_addr_i |
| pc_o | output | 32 | Current program counter (byte address) |
| alu_ovf_o | output | 1 | Signed overflow of the current add or subtract |

## Verification
The bench builds the core with a 32-word instruction memory and a 16-word data memory. This keeps the load address narrow while it still holds a program that exercises every opcode, both outcomes of the branch, a jump over dead code, a load with a negative offset and a self-looping halt. The trace of word PC values checked cycle by cycle covers the sequential, branch, jump and no-op paths. The final register and memory contents, read back through the probes, show which instructions committed and which were skipped.

// File: rtl/sc_pkg.sv
package sc_pkg;
  localparam int XLEN = 32;
  localparam int NREG = 32;
  localparam int RAW  = $clog2(NREG);

  localparam logic [5:0] OP_RTYPE = 6'd0;
  localparam logic [5:0] OP_J     = 6'd2;
  localparam logic [5:0] OP_BEQ   = 6'd4;
  localparam logic [5:0] OP_LW    = 6'd35;
  localparam logic [5:0] OP_SW    = 6'd43;

  localparam logic [5:0] FN_ADD = 6'd32;
  localparam logic [5:0] FN_SUB = 6'd34;
  localparam logic [5:0] FN_AND = 6'd36;
  localparam logic [5:0] FN_OR  = 6'd37;
  localparam logic [5:0] FN_SLT = 6'd42;

  typedef enum logic [2:0] {
    ALU_ADD, ALU_SUB, ALU_AND, ALU_OR, ALU_SLT
  } alu_fn_e;

  typedef struct packed {
    logic    reg_dst;
    logic    alu_src;
    logic    mem_to_reg;
    logic    reg_write;
    logic    mem_read;
    logic    mem_write;
    logic    branch;
    logic    jump;
    alu_fn_e alu_fn;
  } ctrl_t;
endpackage

// File: rtl/sc_ctrl.sv
module sc_ctrl
  import sc_pkg::*;
(
  input  logic [5:0] op_i,
  input  logic [5:0] funct_i,
  output ctrl_t      ctrl_o
);
  always_comb begin
    ctrl_o        = '0;
    ctrl_o.alu_fn = ALU_ADD;
    case (op_i)
      OP_RTYPE: begin
        ctrl_o.reg_dst   = 1'b1;
        ctrl_o.reg_write = 1'b1;
        case (funct_i)
          FN_ADD:  ctrl_o.alu_fn = ALU_ADD;
          FN_SUB:  ctrl_o.alu_fn = ALU_SUB;
          FN_AND:  ctrl_o.alu_fn = ALU_AND;
          FN_OR:   ctrl_o.alu_fn = ALU_OR;
          FN_SLT:  ctrl_o.alu_fn = ALU_SLT;
          default: ctrl_o.reg_write = 1'b0;  // unknown funct: no-op
        endcase
      end
      OP_LW: begin
        ctrl_o.alu_src    = 1'b1;
        ctrl_o.mem_to_reg = 1'b1;
        ctrl_o.reg_write  = 1'b1;
        ctrl_o.mem_read   = 1'b1;
      end
      OP_SW: begin
        ctrl_o.alu_src   = 1'b1;
        ctrl_o.mem_write = 1'b1;
      end
      OP_BEQ: begin
        ctrl_o.branch = 1'b1;
        ctrl_o.alu_fn = ALU_SUB;
      end
      OP_J:    ctrl_o.jump = 1'b1;
      default: ;
    endcase
  end
endmodule

// File: rtl/sc_alu.sv
module sc_alu
  import sc_pkg::*;
#(
  parameter int W = XLEN
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  alu_fn_e      fn_i,
  output logic [W-1:0] res_o,
  output logic         zero_o,
  output logic         ovf_o
);
  logic [W-1:0] sum, dif;

  assign sum = a_i + b_i;
  assign dif = a_i - b_i;

  always_comb begin
    res_o = sum;
    ovf_o = 1'b0;
    case (fn_i)
      ALU_ADD: begin
        res_o = sum;
        ovf_o = (a_i[W-1] == b_i[W-1]) && (sum[W-1] != a_i[W-1]);
      end
      ALU_SUB: begin
        res_o = dif;
        ovf_o = (a_i[W-1] != b_i[W-1]) && (dif[W-1] != a_i[W-1]);
      end
      ALU_AND: res_o = a_i & b_i;
      ALU_OR:  res_o = a_i | b_i;
      ALU_SLT: res_o = {{(W-1){1'b0}}, ($signed(a_i) < $signed(b_i))};
      default: res_o = sum;
    endcase
  end

  assign zero_o = (res_o == '0);
endmodule

// File: rtl/sc_regfile.sv
module sc_regfile
  import sc_pkg::*;
#(
  parameter int N = NREG,
  parameter int W = XLEN,
  localparam int AW = $clog2(N)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] ra1_i,
  input  logic [AW-1:0] ra2_i,
  input  logic [AW-1:0] ra3_i,
  output logic [W-1:0]  rd1_o,
  output logic [W-1:0]  rd2_o,
  output logic [W-1:0]  rd3_o,
  input  logic          we_i,
  input  logic [AW-1:0] wa_i,
  input  logic [W-1:0]  wd_i
);
  logic [W-1:0] mem_q [N];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < N; i++) mem_q[i] <= '0;
    end else if (we_i && wa_i != '0) begin
      mem_q[wa_i] <= wd_i;
    end
  end

  assign rd1_o = mem_q[ra1_i];
  assign rd2_o = mem_q[ra2_i];
  assign rd3_o = mem_q[ra3_i];

  // R2
  write_lands_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && wa_i != '0) |=> mem_q[$past(wa_i)] == $past(wd_i));

  // R8
  zero_reg_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ra1_i == '0) |-> (rd1_o == '0));
endmodule

// File: rtl/sc_wordmem.sv
module sc_wordmem #(
  parameter int WORDS = 64,
  parameter int W     = 32,
  parameter int NRD   = 1,
  localparam int AW   = $clog2(WORDS)
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [W-1:0]  wdata_i,
  input  logic [AW-1:0] raddr_i [NRD],
  output logic [W-1:0]  rdata_o [NRD]
);
  logic [W-1:0] mem_q [WORDS];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  for (genvar g = 0; g < NRD; g++) begin : g_rd
    assign rdata_o[g] = mem_q[raddr_i[g]];
  end
endmodule

// File: rtl/sc_core.sv
module sc_core
  import sc_pkg::*;
#(
  parameter int IMEM_WORDS = 64,
  parameter int DMEM_WORDS = 64,
  localparam int IAW = $clog2(IMEM_WORDS),
  localparam int DAW = $clog2(DMEM_WORDS),
  localparam int LAW = (IAW > DAW) ? IAW : DAW
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            load_we_i,
  input  logic            load_imem_i,
  input  logic [LAW-1:0]  load_addr_i,
  input  logic [XLEN-1:0] load_data_i,
  input  logic [RAW-1:0]  probe_reg_i,
  output logic [XLEN-1:0] probe_reg_o,
  output logic [XLEN-1:0] probe_mem_o,
  output logic [XLEN-1:0] pc_o,
  output logic            alu_ovf_o
);
  logic [XLEN-1:0] pc_q, pc_d, pc_plus4, br_tgt, jmp_tgt, pc_br, imm_sx;
  logic [XLEN-1:0] instr, rs_val, rt_val, alu_b, alu_res, ld_data, wb_data;
  logic [5:0]      op, funct;
  logic [RAW-1:0]  rs, rt, rd, wr_reg;
  logic            alu_zero, br_taken, run;
  ctrl_t           ctl;

  assign op    = instr[31:26];
  assign rs    = instr[25:21];
  assign rt    = instr[20:16];
  assign rd    = instr[15:11];
  assign funct = instr[5:0];
  assign run   = rst_ni && !load_we_i;

  // instruction memory
  logic [IAW-1:0]  im_ra [1];
  logic [XLEN-1:0] im_rd [1];
  assign im_ra[0] = pc_q[IAW+1:2];
  assign instr    = im_rd[0];

  sc_wordmem #(.WORDS(IMEM_WORDS), .W(XLEN), .NRD(1)) u_imem (
    .clk_i   (clk_i),
    .we_i    (load_we_i && load_imem_i),
    .waddr_i (load_addr_i[IAW-1:0]),
    .wdata_i (load_data_i),
    .raddr_i (im_ra),
    .rdata_o (im_rd)
  );

  sc_ctrl u_ctrl (.op_i(op), .funct_i(funct), .ctrl_o(ctl));

  sc_regfile #(.N(NREG), .W(XLEN)) u_rf (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .ra1_i  (rs),
    .ra2_i  (rt),
    .ra3_i  (probe_reg_i),
    .rd1_o  (rs_val),
    .rd2_o  (rt_val),
    .rd3_o  (probe_reg_o),
    .we_i   (ctl.reg_write && run),
    .wa_i   (wr_reg),
    .wd_i   (wb_data)
  );

  assign imm_sx = {{(XLEN-16){instr[15]}}, instr[15:0]};
  assign alu_b  = ctl.alu_src ? imm_sx : rt_val;

  sc_alu #(.W(XLEN)) u_alu (
    .a_i    (rs_val),
    .b_i    (alu_b),
    .fn_i   (ctl.alu_fn),
    .res_o  (alu_res),
    .zero_o (alu_zero),
    .ovf_o  (alu_ovf_o)
  );

  // data memory: port 0 core access, port 1 probe
  logic            dm_we;
  logic [DAW-1:0]  dm_wa;
  logic [XLEN-1:0] dm_wd;
  logic [DAW-1:0]  dm_ra [2];
  logic [XLEN-1:0] dm_rd [2];

  assign dm_we    = (load_we_i && !load_imem_i) || (run && ctl.mem_write);
  assign dm_wa    = load_we_i ? load_addr_i[DAW-1:0] : alu_res[DAW+1:2];
  assign dm_wd    = load_we_i ? load_data_i : rt_val;
  assign dm_ra[0] = alu_res[DAW+1:2];
  assign dm_ra[1] = load_addr_i[DAW-1:0];
  assign ld_data  = ctl.mem_read ? dm_rd[0] : '0;
  assign probe_mem_o = dm_rd[1];

  sc_wordmem #(.WORDS(DMEM_WORDS), .W(XLEN), .NRD(2)) u_dmem (
    .clk_i   (clk_i),
    .we_i    (dm_we),
    .waddr_i (dm_wa),
    .wdata_i (dm_wd),
    .raddr_i (dm_ra),
    .rdata_o (dm_rd)
  );

  assign wr_reg  = ctl.reg_dst ? rd : rt;
  assign wb_data = ctl.mem_to_reg ? ld_data : alu_res;

  // next PC: branch mux, then jump mux
  assign pc_plus4 = pc_q + 32'd4;
  assign br_tgt   = pc_plus4 + {imm_sx[XLEN-3:0], 2'b00};
  assign br_taken = ctl.branch && alu_zero;
  assign pc_br    = br_taken ? br_tgt : pc_plus4;
  assign jmp_tgt  = {pc_plus4[31:28], instr[25:0], 2'b00};
  assign pc_d     = ctl.jump ? jmp_tgt : pc_br;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pc_q <= '0;
    else         pc_q <= pc_d;
  end

  assign pc_o = pc_q;

  // R10
  pc_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!br_taken && !ctl.jump) |=> pc_q == $past(pc_q) + 32'd4);

  // R6
  br_target_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (br_taken && rs_val == rt_val) |=> pc_q == $past(pc_q) + 32'd4 + {$past(imm_sx[XLEN-3:0]), 2'b00});

  // R7
  jump_region_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op == OP_J) |=> pc_q[31:28] == $past(pc_plus4[31:28]));

  // R5
  store_only_sw_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run && ctl.mem_write) |-> (op == OP_SW && !ctl.reg_write));

  // R9
  illegal_nop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op != OP_RTYPE && op != OP_J && op != OP_BEQ && op != OP_LW && op != OP_SW)
      |-> (!ctl.reg_write && !ctl.mem_write && !ctl.branch && !ctl.jump));

  // R3
  slt_bool_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op == OP_RTYPE && funct == FN_SLT) |-> alu_res[31:1] == '0);

  // R5
  ctl_exclusive_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({ctl.branch, ctl.jump, ctl.mem_write, ctl.reg_write}));
endmodule

// File: tb/sim_sc_core.sv
module sim_sc_core;
  localparam int IW  = 32;
  localparam int DW  = 16;
  localparam int LAW = 5;

  function automatic logic [31:0] r_ins(int s, int t, int d, logic [5:0] fn);
    return {6'd0, 5'(s), 5'(t), 5'(d), 5'd0, fn};
  endfunction
  function automatic logic [31:0] i_ins(logic [5:0] op, int s, int t, logic [15:0] imm);
    return {op, 5'(s), 5'(t), imm};
  endfunction
  function automatic logic [31:0] j_ins(logic [25:0] tgt);
    return {6'd2, tgt};
  endfunction

  localparam int NPROG = 22;
  localparam logic [31:0] PROG [NPROG] = '{
    i_ins(6'd35, 0, 1, 16'd0),       // 0  lw r1,0(r0)
    i_ins(6'd35, 0, 2, 16'd4),       // 1  lw r2,4(r0)
    r_ins(1, 2, 3, 6'd32),           // 2  add r3
    r_ins(1, 2, 4, 6'd34),           // 3  sub r4
    r_ins(1, 2, 5, 6'd36),           // 4  and r5
    r_ins(1, 2, 6, 6'd37),           // 5  or r6
    r_ins(2, 1, 7, 6'd42),           // 6  slt r7 = (-3 < 5)
    r_ins(1, 2, 8, 6'd42),           // 7  slt r8 = (5 < -3)
    i_ins(6'd43, 0, 4, 16'd8),       // 8  sw r4,8(r0)
    r_ins(1, 1, 0, 6'd32),           // 9  add r0 (discarded)
    i_ins(6'd4, 1, 2, 16'd5),        // 10 beq not taken
    i_ins(6'd4, 3, 3, 16'd2),        // 11 beq taken -> 14
    r_ins(1, 1, 9, 6'd32),           // 12 skipped
    r_ins(1, 1, 9, 6'd32),           // 13 skipped
    i_ins(6'h3f, 1, 10, 16'd7),      // 14 unknown op
    r_ins(1, 1, 11, 6'h3f),          // 15 unknown funct
    j_ins(26'd19),                   // 16 j -> 19
    r_ins(1, 1, 12, 6'd32),          // 17 skipped
    r_ins(1, 1, 12, 6'd32),          // 18 skipped
    i_ins(6'd35, 4, 13, 16'hfffc),   // 19 lw r13,-4(r4)
    i_ins(6'd43, 0, 13, 16'd12),     // 20 sw r13,12(r0)
    i_ins(6'd4, 0, 0, 16'hffff)      // 21 beq loop
  };

  localparam int NTR = 19;
  localparam int TRACE [NTR] = '{0,1,2,3,4,5,6,7,8,9,10,11,14,15,16,19,20,21,21};

  localparam int NREGX = 14;
  localparam logic [31:0] REG_EXP [NREGX] = '{
    32'd0, 32'd5, 32'hfffffffd, 32'd2, 32'd8, 32'd5, 32'hfffffffd,
    32'd1, 32'd0, 32'd0, 32'd0, 32'd0, 32'd0, 32'hfffffffd
  };

  localparam int NMEMX = 5;
  localparam logic [31:0] MEM_EXP [NMEMX] = '{32'd5, 32'hfffffffd, 32'd8, 32'hfffffffd, 32'd0};

  logic            clk = 1'b0;
  logic            rst_ni = 1'b0;
  logic            load_we = 1'b0, load_imem = 1'b0;
  logic [LAW-1:0]  load_addr = '0;
  logic [31:0]     load_data = '0;
  logic [4:0]      probe_reg = '0;
  logic [31:0]     probe_reg_o, probe_mem_o, pc_o;
  logic            alu_ovf;
  int              checks = 0, errors = 0;

  always #5 clk = ~clk;

  sc_core #(.IMEM_WORDS(IW), .DMEM_WORDS(DW)) u0 (
    .clk_i       (clk),
    .rst_ni      (rst_ni),
    .load_we_i   (load_we),
    .load_imem_i (load_imem),
    .load_addr_i (load_addr),
    .load_data_i (load_data),
    .probe_reg_i (probe_reg),
    .probe_reg_o (probe_reg_o),
    .probe_mem_o (probe_mem_o),
    .pc_o        (pc_o),
    .alu_ovf_o   (alu_ovf)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic string reg_req(int r);
    case (r)
      0:              return "R8 r0";
      1, 2, 13:       return "R4 load";
      3, 4, 5, 6:     return "R2 rtype";
      7, 8:           return "R3 slt";
      9:              return "R6 skipped by branch";
      10, 11:         return "R9 no-op";
      default:        return "R7 skipped by jump";
    endcase
  endfunction

  function automatic string pc_req(int k);
    case (k)
      11, 12, 17, 18: return "R6 branch pc";
      13, 14:         return "R9 no-op pc";
      15:             return "R7 jump pc";
      default:        return "R10 pc step";
    endcase
  endfunction

  task automatic load_word(logic imem, int a, logic [31:0] d);
    @(negedge clk);
    load_we = 1'b1; load_imem = imem; load_addr = LAW'(a); load_data = d;
    @(negedge clk);
    load_we = 1'b0;
  endtask

  initial begin
    #2_000_000;
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < IW; i++) load_word(1'b1, i, (i < NPROG) ? PROG[i] : 32'd0);
    for (int i = 0; i < DW; i++)
      load_word(1'b0, i, (i == 0) ? 32'd5 : (i == 1) ? 32'hfffffffd : 32'd0);

    // R1 reset state
    @(negedge clk);
    check("R1 reset pc", pc_o, 32'd0);
    probe_reg = 5'd1; #1;
    check("R1 reset reg", probe_reg_o, 32'd0);

    rst_ni = 1'b1;
    for (int k = 0; k < NTR; k++) begin
      #1;
      check(pc_req(k), pc_o, 32'(TRACE[k] * 4));
      @(negedge clk);
    end
    repeat (10) @(negedge clk);
    check("R6 halt loop pc", pc_o, 32'd84);

    for (int r = 0; r < NREGX; r++) begin
      probe_reg = 5'(r); #1;
      check(reg_req(r), probe_reg_o, REG_EXP[r]);
    end
    for (int m = 0; m < NMEMX; m++) begin
      load_addr = LAW'(m); #1;
      check((m < 2) ? "R4 preload kept" : "R5 store", probe_mem_o, MEM_EXP[m]);
    end

    // R1 reset reapplied mid-run
    @(negedge clk);
    rst_ni = 1'b0; #1;
    check("R1 pc cleared", pc_o, 32'd0);
    probe_reg = 5'd4; #1;
    check("R1 reg cleared", probe_reg_o, 32'd0);
    @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    check("R10 restart step", pc_o, 32'd4);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule